// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is a three-stage multiply-accumulate execution unit. Each cycle it can take one operation made of two 32-bit operands, a size selector, a sign selector and an opcode. It either returns a plain integer product or updates a 32-bit internal accumulator by adding the product to it, subtracting the product from it, or clearing it. Half-width (16x16) operations use the low halves of the operands and issue every cycle. Full-width (32x32) operations are split into three 16-bit partial-product passes through one shared multiplier array, so the operand port stalls for two cycles after such an operation is taken.

Every operation retires in issue order in the last stage, and the accumulator is written only in that stage. A multiply-accumulate issued right behind another therefore sees the newest accumulator value with no bubble. The result port pulses once for every retired operation. The accumulator read port shows the value the accumulator holds once all retired operations are applied. A busy flag tells a reader when no accepted operation is still in flight.

Top module: `mac_unit`

## Requirements
- R1: After reset, `in_ready_o` is 1, `res_valid_o` is 0, `busy_o` is 0 and `acc_o` is 0.
- R2: An operation is taken on a clock edge where `in_valid_i` and `in_ready_o` are both 1. After a half-width operation (`wide_i`=0) or a clear operation, `in_ready_o` stays 1, so such operations can issue on every cycle.
- R3: After a full-width operation (`wide_i`=1) other than clear, `in_ready_o` is 0 for exactly the two cycles that follow the accepting edge. It is 1 again in the third cycle.
- R4: The result of a half-width operation or a clear is on `res_o` with `res_valid_o`=1 in the cycle that follows the third clock edge, counting the accepting edge as the first. A full-width result appears two cycles later than that.
- R5: Opcode `op_i` 0 is a plain multiply. `res_o` is the low 32 bits of the product and the accumulator does not change. With `wide_i`=0 the operands are bits 15:0 of `op_a_i` and `op_b_i`. These are sign-extended when `signed_i`=1 and zero-extended when it is 0. With `wide_i`=1 the operands are the full 32-bit inputs.
- R6: Opcode 1 adds the product to the accumulator and opcode 2 subtracts it, both modulo 2^32. `res_o` carries the new accumulator value. Back-to-back accumulate operations chain with no bubble.
- R7: Opcode 3 sets the accumulator to zero and returns zero on `res_o`, whatever the operand values are.
- R8: `busy_o` is 1 while any accepted operation has not yet retired. When it is 0, `acc_o` equals the accumulator after every accepted operation.
- R9: `res_valid_o` pulses exactly once for each accepted operation, and results come out in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can take an operation this cycle |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| wide_i | input | 1 | 1 selects 32x32, 0 selects 16x16 |
| signed_i | input | 1 | 1 treats operands as two's complement |
| op_i | input | 2 | 0 multiply, 1 accumulate, 2 subtract, 3 clear |
| res_valid_o | output | 1 | Result pulse for one retired operation |
| res_o | output | 32 | Product, or new accumulator value |
| acc_o | output | 32 | Accumulator after retired operations |
| busy_o | output | 1 | Accepted operations still in flight |

## Verification
The assertions assume that an offered operation keeps its fields stable while `in_ready_o` is low. They also assume that nothing outside the operand port changes the accumulator. The latency properties therefore hold only when every offered operation is eventually taken. The stimulus meets these assumptions by changing the operand fields only at the falling edge after the unit has taken the previous offer, and by holding a refused offer unchanged until it is taken. The random mix covers every combination of size, sign and opcode, with idle gaps of random length between operations.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL = 2'd0,
    OP_MAC = 2'd1,
    OP_MSU = 2'd2,
    OP_CLR = 2'd3
  } mac_op_e;

  // partial-product passes for a full-width operation
  localparam int unsigned NPASS = 3;
endpackage

// File: rtl/mac_issue.sv
module mac_issue
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2,
  localparam int unsigned EW = HW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  input  logic          wide_i,
  input  logic          signed_i,
  input  mac_op_e       op_i,
  output logic          uop_valid_o,
  output logic [EW-1:0] uop_a_o,
  output logic [EW-1:0] uop_b_o,
  output logic          uop_shift_o,
  output logic          uop_first_o,
  output logic          uop_last_o,
  output mac_op_e       uop_op_o
);
  logic          v_q, wide_q, sgn_q;
  logic [DW-1:0] a_q, b_q;
  mac_op_e       op_q;
  logic [1:0]    pass_q;
  logic          single_w, last_w, accept_w;
  logic [EW-1:0] a_lo, a_hi, a_nar, b_lo, b_hi, b_nar;

  assign single_w   = !wide_q || (op_q == OP_CLR);
  assign last_w     = single_w || (pass_q == 2'(NPASS - 1));
  assign in_ready_o = !v_q || last_w;
  assign accept_w   = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      wide_q <= 1'b0;
      sgn_q  <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      op_q   <= OP_MUL;
      pass_q <= '0;
    end else if (accept_w) begin
      v_q    <= 1'b1;
      wide_q <= wide_i;
      sgn_q  <= signed_i;
      a_q    <= op_a_i;
      b_q    <= op_b_i;
      op_q   <= op_i;
      pass_q <= '0;
    end else if (v_q && last_w) begin
      v_q <= 1'b0;
    end else if (v_q) begin
      pass_q <= pass_q + 2'd1;
    end
  end

  // low halves are magnitudes; high and narrow halves carry the sign
  always_comb begin
    a_lo  = {1'b0, a_q[HW-1:0]};
    b_lo  = {1'b0, b_q[HW-1:0]};
    a_hi  = {sgn_q & a_q[DW-1], a_q[DW-1:HW]};
    b_hi  = {sgn_q & b_q[DW-1], b_q[DW-1:HW]};
    a_nar = {sgn_q & a_q[HW-1], a_q[HW-1:0]};
    b_nar = {sgn_q & b_q[HW-1], b_q[HW-1:0]};
    uop_shift_o = 1'b0;
    if (single_w) begin
      uop_a_o = a_nar;
      uop_b_o = b_nar;
    end else begin
      unique case (pass_q)
        2'd0: begin
          uop_a_o = a_lo;
          uop_b_o = b_lo;
        end
        2'd1: begin
          uop_a_o     = a_hi;
          uop_b_o     = b_lo;
          uop_shift_o = 1'b1;
        end
        default: begin
          uop_a_o     = a_lo;
          uop_b_o     = b_hi;
          uop_shift_o = 1'b1;
        end
      endcase
    end
  end

  assign uop_valid_o = v_q;
  assign uop_first_o = (pass_q == 2'd0);
  assign uop_last_o  = last_w;
  assign uop_op_o    = op_q;
endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2,
  localparam int unsigned EW = HW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic          shift_i,
  input  logic          first_i,
  input  logic          last_i,
  input  mac_op_e       op_i,
  output logic          valid_o,
  output logic [DW-1:0] prod_o,
  output logic          shift_o,
  output logic          first_o,
  output logic          last_o,
  output mac_op_e       op_o
);
  logic [DW-1:0] ax, bx, px;

  // only the low DW bits of the product are needed
  assign ax = {{(DW-EW){a_i[EW-1]}}, a_i};
  assign bx = {{(DW-EW){b_i[EW-1]}}, b_i};
  assign px = ax * bx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
      shift_o <= 1'b0;
      first_o <= 1'b0;
      last_o  <= 1'b0;
      op_o    <= OP_MUL;
    end else begin
      valid_o <= valid_i;
      prod_o  <= px;
      shift_o <= shift_i;
      first_o <= first_i;
      last_o  <= last_i;
      op_o    <= op_i;
    end
  end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] prod_i,
  input  logic          shift_i,
  input  logic          first_i,
  input  logic          last_i,
  input  mac_op_e       op_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] acc_o
);
  logic [DW-1:0] acc_q, sum_q, pp_sh, full_w, acc_add, acc_sub;

  assign pp_sh   = shift_i ? (prod_i << HW) : prod_i;
  assign full_w  = first_i ? pp_sh : (sum_q + pp_sh);
  assign acc_add = acc_q + full_w;
  assign acc_sub = acc_q - full_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q       <= '0;
      sum_q       <= '0;
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= valid_i && last_i;
      if (valid_i && !last_i) begin
        sum_q <= full_w;
      end else if (valid_i) begin
        unique case (op_i)
          OP_MUL: res_o <= full_w;
          OP_MAC: begin
            acc_q <= acc_add;
            res_o <= acc_add;
          end
          OP_MSU: begin
            acc_q <= acc_sub;
            res_o <= acc_sub;
          end
          default: begin
            acc_q <= '0;
            res_o <= '0;
          end
        endcase
      end
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned HW = DW / 2,
  localparam int unsigned EW = HW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  input  logic          wide_i,
  input  logic          signed_i,
  input  logic [1:0]    op_i,
  output logic          res_valid_o,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] acc_o,
  output logic          busy_o
);
  mac_op_e       op_w, s1_op, s2_op;
  logic          s1_v, s1_shift, s1_first, s1_last;
  logic [EW-1:0] s1_a, s1_b;
  logic          s2_v, s2_shift, s2_first, s2_last;
  logic [DW-1:0] s2_prod;

  assign op_w = mac_op_e'(op_i);

  mac_issue #(.DW(DW)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .op_a_i      (op_a_i),
    .op_b_i      (op_b_i),
    .wide_i      (wide_i),
    .signed_i    (signed_i),
    .op_i        (op_w),
    .uop_valid_o (s1_v),
    .uop_a_o     (s1_a),
    .uop_b_o     (s1_b),
    .uop_shift_o (s1_shift),
    .uop_first_o (s1_first),
    .uop_last_o  (s1_last),
    .uop_op_o    (s1_op)
  );

  mac_mult #(.DW(DW)) u_mult (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_v),
    .a_i     (s1_a),
    .b_i     (s1_b),
    .shift_i (s1_shift),
    .first_i (s1_first),
    .last_i  (s1_last),
    .op_i    (s1_op),
    .valid_o (s2_v),
    .prod_o  (s2_prod),
    .shift_o (s2_shift),
    .first_o (s2_first),
    .last_o  (s2_last),
    .op_o    (s2_op)
  );

  mac_accum #(.DW(DW)) u_accum (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (s2_v),
    .prod_i      (s2_prod),
    .shift_i     (s2_shift),
    .first_i     (s2_first),
    .last_i      (s2_last),
    .op_i        (s2_op),
    .res_valid_o (res_valid_o),
    .res_o       (res_o),
    .acc_o       (acc_o)
  );

  assign busy_o = s1_v || s2_v;
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          in_ready_o,
  input logic          wide_i,
  input logic [1:0]    op_i,
  input logic          res_valid_o,
  input logic [DW-1:0] acc_o,
  input logic          busy_o
);
  logic take_w, narrow_w;
  assign take_w   = in_valid_i && in_ready_o;
  assign narrow_w = !wide_i || (op_i == 2'd3);

  AST_NARROW_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_w && narrow_w) |=> in_ready_o);  // R2

  AST_WIDE_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_w && !narrow_w) |=> !in_ready_o);  // R3

  AST_NARROW_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_w && narrow_w) |-> ##3 res_valid_o);  // R4

  AST_ACC_ONLY_ON_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> $stable(acc_o));  // R6

  AST_IDLE_IS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> in_ready_o);  // R8
endmodule

bind mac_unit mac_unit_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .wide_i      (wide_i),
  .op_i        (op_i),
  .res_valid_o (res_valid_o),
  .acc_o       (acc_o),
  .busy_o      (busy_o)
);

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] op_a_i = '0;
  logic [31:0] op_b_i = '0;
  logic        wide_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic        res_valid_o;
  logic [31:0] res_o;
  logic [31:0] acc_o;
  logic        busy_o;

  mac_unit dut (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int stall = 0;
  logic [31:0] m_acc = '0;
  logic [31:0] q_val[$];
  int          q_due[$];
  string       q_tag[$];

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycle %0d expected below 150000", cyc);
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  function automatic logic [31:0] ref_prod(logic [31:0] a, logic [31:0] b, logic w, logic s);
    logic [63:0] x, y, p;
    if (w) begin
      x = {32'b0, a};
      y = {32'b0, b};
    end else begin
      x = s ? {{48{a[15]}}, a[15:0]} : {48'b0, a[15:0]};
      y = s ? {{48{b[15]}}, b[15:0]} : {48'b0, b[15:0]};
    end
    p = x * y;
    return p[31:0];
  endfunction

  // per-negedge output check
  task automatic observe();
    chk("R2/R3 in_ready", {31'b0, in_ready_o}, {31'b0, stall == 0});
    if (stall > 0) stall--;
    if (res_valid_o) begin
      if (q_val.size() == 0) begin
        chk("R9 spurious result", 32'd1, 32'd0);
      end else begin
        chk(q_tag[0], res_o, q_val[0]);
        chk("R4 latency", cyc, q_due[0]);
        void'(q_val.pop_front());
        void'(q_due.pop_front());
        void'(q_tag.pop_front());
      end
    end
    if (q_val.size() == 0) begin
      chk("R8 busy idle", {31'b0, busy_o}, 32'd0);
      chk("R8 acc read", acc_o, m_acc);
    end else begin
      chk("R8 busy in flight", {31'b0, busy_o}, 32'd1);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      observe();
      in_valid_i = 1'b0;
    end
  endtask

  task automatic issue(logic [31:0] a, logic [31:0] b, logic w, logic s, logic [1:0] op);
    logic [31:0] p, e;
    string t;
    forever begin
      @(negedge clk_i);
      observe();
      in_valid_i = 1'b1;
      op_a_i = a;
      op_b_i = b;
      wide_i = w;
      signed_i = s;
      op_i = op;
      if (in_ready_o) break;
    end
    p = ref_prod(a, b, w, s);
    case (op)
      2'd0: begin e = p; t = "R5 multiply"; end
      2'd1: begin m_acc = m_acc + p; e = m_acc; t = "R6 accumulate"; end
      2'd2: begin m_acc = m_acc - p; e = m_acc; t = "R6 subtract"; end
      default: begin m_acc = '0; e = '0; t = "R7 clear"; end
    endcase
    q_val.push_back(e);
    q_tag.push_back(t);
    if (w && op != 2'd3) begin
      q_due.push_back(cyc + 5);
      stall = 2;
    end else begin
      q_due.push_back(cyc + 3);
    end
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk_i);
    chk("R1 ready", {31'b0, in_ready_o}, 32'd1);
    chk("R1 res_valid", {31'b0, res_valid_o}, 32'd0);
    chk("R1 busy", {31'b0, busy_o}, 32'd0);
    chk("R1 acc", acc_o, 32'd0);
    rst_ni = 1'b1;
    idle(2);
    // R5 directed: sign extension of the low halves
    issue(32'h1234_FFFF, 32'h0000_0002, 1'b0, 1'b1, 2'd0);
    issue(32'h1234_FFFF, 32'h0000_0002, 1'b0, 1'b0, 2'd0);
    issue(32'hFFFF_8000, 32'h0000_8000, 1'b0, 1'b1, 2'd0);
    issue(32'h8000_0001, 32'hFFFF_FFFF, 1'b1, 1'b1, 2'd0);
    issue(32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b0, 2'd0);
    // R6 back-to-back chain, then R7 clear with junk operands
    issue(32'd3, 32'd5, 1'b0, 1'b0, 2'd1);
    issue(32'd7, 32'd9, 1'b0, 1'b0, 2'd1);
    issue(32'h0001_0000, 32'h0001_0000, 1'b1, 1'b0, 2'd1);
    issue(32'hFFFF, 32'hFFFF, 1'b0, 1'b0, 2'd2);
    issue(32'hDEAD_BEEF, 32'hCAFE_F00D, 1'b1, 1'b1, 2'd3);
    issue(32'd1, 32'd1, 1'b0, 1'b0, 2'd2);  // wraps below zero
    issue(32'hFFFF_FFFF, 32'h2, 1'b1, 1'b1, 2'd1);
    idle(8);
    for (int k = 0; k < 2500; k++) begin
      logic [31:0] ra, rb;
      logic [1:0]  rop;
      ra = $urandom();
      rb = $urandom();
      rop = 2'($urandom_range(0, 3));
      if (rop == 2'd3 && $urandom_range(0, 3) != 0) rop = 2'd1;
      issue(ra, rb, 1'($urandom()), 1'($urandom()), rop);
      if ($urandom_range(0, 4) == 0) idle(int'($urandom_range(1, 4)));
    end
    idle(10);
    chk("R9 all results seen", q_val.size(), 32'd0);
    summary();
  end
endmodule